// File: doc/BRIEF.md
# Configurable Product-Term Logic Cell

This block is one logic cell of a sum-of-products programmable fabric. A bank of configuration words decides which input literals (each input in true or inverted form) are wired into each AND product term, and which product terms are ORed together into the cell's sum. The sum either goes straight to the outputs or passes through a D flip-flop first. The flip-flop's clock can be the dedicated global clock or a product term. Its clear can be the dedicated active-low global clear or a product term.

The cell result drives two outputs that always carry the same value. One output feeds back into the interconnect so that another cell can use it. The other drives a pin, whose enable comes from one of two global output-enable inputs. Configuration is written one word per global clock cycle through a parallel port with a write strobe. A small state machine masks the outputs until a commit write marks the configuration complete.

The configuration state machine has three states. CFG_BLANK is entered at reset. CFG_LOADING is entered on any field write. CFG_LIVE is entered on a commit write. Its transitions are:
- BLANK→LOADING on a field write.
- BLANK→LIVE on a commit write.
- LOADING→LIVE on a commit write.
- LIVE→LOADING on a field write.
All other cases hold the current state.

Top module: `macrocell_pterm`

## Requirements
- R1: Term row i is written at address i (0..N_PT-1). In that row, bit 2k connects input k in true form and bit 2k+1 connects input k in inverted form.
- R2: A product term is the AND of the literals whose connection bits are set. A row with no bits set gives a term of 0.
- R3: The control word at address N_PT selects terms with bits [N_PT-1:0], and the sum is the OR of the selected terms. A sum with no selected terms is 0. With term 0 = A·C·!D, term 1 = B·C·!D and both selected, the cell computes (A+B)·C·!D.
- R4: Control bit 8 set (bypass) makes the outputs follow the sum combinationally. Cleared, the outputs show the flip-flop, which loads the sum on a rising clock edge.
- R5: Control bit 9 clear clocks the flip-flop from gclk. Set, it clocks on the rising edge of term N_PT-1, and gclk edges have no effect.
- R6: Control bit 10 clear makes gclr_n low clear the flip-flop to 0 asynchronously. Set, term N_PT-2 high clears it instead, and gclr_n is ignored. While the clear is active, clock edges do not load the flip-flop.
- R7: fb_out and pin_out both carry the cell result.
- R8: Control bit 11 selects the pin enable: 0 selects oe_a, 1 selects oe_b.
- R9: After reset, and after any field write until the next commit write (address N_PT+1, data ignored), fb_out, pin_out and pin_oe are 0.
- R10: A write to an address above N_PT+1 changes neither the configuration nor the state machine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | Global clock; clocks configuration and, when selected, the cell flip-flop |
| rst_n | input | 1 | Active-low reset of configuration, state machine and flip-flop |
| gclr_n | input | 1 | Global active-low asynchronous clear |
| oe_a | input | 1 | First global output enable |
| oe_b | input | 1 | Second global output enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W (3) | Configuration word address |
| cfg_wdata | input | CFG_W (16) | Configuration word data |
| din | input | N_IN (8) | Array inputs from the interconnect |
| fb_out | output | 1 | Cell result toward the interconnect |
| pin_out | output | 1 | Cell result toward the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
The bench uses the default 8 inputs and 5 product terms. With these values, the clock term (4) and the clear term (3) are separate from terms 0 to 2, so the two-term example and the product-term clocking and clearing can be exercised in one cell. The 3-bit address leaves one unused code (7) for the ignored-write case. Random rows with sparse literals give a fair share of true terms, and the bench mixes them with empty rows and empty selections.

// File: rtl/mc_pkg.sv
package mc_pkg;
    // configuration sequencing states
    typedef enum logic [1:0] {
        CFG_BLANK   = 2'd0,
        CFG_LOADING = 2'd1,
        CFG_LIVE    = 2'd2
    } cfg_state_e;

    // control word bit positions (term select occupies the low bits)
    localparam int CTL_BYPASS = 8;
    localparam int CTL_CLK_PT = 9;
    localparam int CTL_CLR_PT = 10;
    localparam int CTL_OE_SEL = 11;
    localparam int CTL_MIN_W  = 12;
endpackage

// File: rtl/mc_cfg_loader.sv
module mc_cfg_loader
    import mc_pkg::*;
#(
    parameter int N_PT   = 5,
    parameter int LIT_W  = 16,
    parameter int CFG_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [CFG_W-1:0]            wdata,
    output logic [N_PT-1:0][LIT_W-1:0]  rows,
    output logic [CFG_W-1:0]            ctl,
    output logic                        live
);
    localparam logic [ADDR_W-1:0] CTL_ADDR    = ADDR_W'(N_PT);
    localparam logic [ADDR_W-1:0] COMMIT_ADDR = ADDR_W'(N_PT + 1);

    cfg_state_e state, state_nx;
    logic       wr_field;
    logic       wr_commit;

    assign wr_field  = we && (addr <= CTL_ADDR);
    assign wr_commit = we && (addr == COMMIT_ADDR);

    // term row storage, one word per product term
    for (genvar i = 0; i < N_PT; i++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rows[i] <= '0;
            end else if (we && (addr == ADDR_W'(i))) begin
                rows[i] <= wdata[LIT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (we && (addr == CTL_ADDR)) begin
            ctl <= wdata;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CFG_BLANK;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            CFG_BLANK: begin
                if (wr_commit) begin
                    state_nx = CFG_LIVE;
                end else if (wr_field) begin
                    state_nx = CFG_LOADING;
                end
            end
            CFG_LOADING: begin
                if (wr_commit) begin
                    state_nx = CFG_LIVE;
                end
            end
            CFG_LIVE: begin
                if (wr_field) begin
                    state_nx = CFG_LOADING;
                end
            end
            default: state_nx = CFG_BLANK;
        endcase
    end

    // outputs
    always_comb begin
        live = 1'b0;
        unique case (state)
            CFG_BLANK:   live = 1'b0;
            CFG_LOADING: live = 1'b0;
            CFG_LIVE:    live = 1'b1;
            default:     live = 1'b0;
        endcase
    end
endmodule

// File: rtl/mc_and_array.sv
module mc_and_array #(
    parameter int N_IN = 8,
    parameter int N_PT = 5,
    parameter int LIT_W = 2 * N_IN
) (
    input  logic [N_IN-1:0]             din,
    input  logic [N_PT-1:0][LIT_W-1:0]  rows,
    output logic [N_PT-1:0]             pt
);
    logic [LIT_W-1:0] lit;

    // literal 2k is the input, literal 2k+1 its inverse
    for (genvar k = 0; k < N_IN; k++) begin : g_lit
        assign lit[2*k]     = din[k];
        assign lit[2*k + 1] = ~din[k];
    end

    // an unconnected row is a forced-low term
    for (genvar i = 0; i < N_PT; i++) begin : g_term
        assign pt[i] = (|rows[i]) & (&(lit | ~rows[i]));
    end
endmodule

// File: rtl/mc_or_select.sv
module mc_or_select #(
    parameter int N_PT = 5
) (
    input  logic [N_PT-1:0] pt,
    input  logic [N_PT-1:0] sel,
    output logic            sum
);
    assign sum = |(pt & sel);
endmodule

// File: rtl/mc_storage.sv
module mc_storage (
    input  logic gclk,
    input  logic rst_n,
    input  logic gclr_n,
    input  logic pt_clk,
    input  logic pt_clr,
    input  logic clk_pt_mode,
    input  logic clr_pt_mode,
    input  logic d,
    output logic q
);
    logic ff_clk;
    logic ff_clr_n;

    assign ff_clk   = clk_pt_mode ? pt_clk : gclk;
    assign ff_clr_n = rst_n & (clr_pt_mode ? ~pt_clr : gclr_n);

    always_ff @(posedge ff_clk or negedge ff_clr_n) begin
        if (!ff_clr_n) begin
            q <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/macrocell_pterm.sv
module macrocell_pterm
    import mc_pkg::*;
#(
    parameter  int N_IN   = 8,
    parameter  int N_PT   = 5,
    localparam int LIT_W  = 2 * N_IN,
    localparam int CFG_W  = (LIT_W > CTL_MIN_W) ? LIT_W : CTL_MIN_W,
    localparam int ADDR_W = $clog2(N_PT + 3)
) (
    input  logic              gclk,
    input  logic              rst_n,
    input  logic              gclr_n,
    input  logic              oe_a,
    input  logic              oe_b,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [N_IN-1:0]   din,
    output logic              fb_out,
    output logic              pin_out,
    output logic              pin_oe
);
    localparam int CLK_TERM = N_PT - 1;
    localparam int CLR_TERM = N_PT - 2;

    logic [N_PT-1:0][LIT_W-1:0] rows;
    logic [CFG_W-1:0]           ctl;
    logic                       live;
    logic [N_PT-1:0]            pt_w;
    logic [N_PT-1:0]            sel_w;
    logic                       sum_w;
    logic                       cell_q;
    logic                       cell_res;
    logic                       bypass_en;
    logic                       clk_pt_mode;
    logic                       clr_pt_mode;
    logic                       oe_sel;

    assign sel_w       = ctl[N_PT-1:0];
    assign bypass_en   = ctl[CTL_BYPASS];
    assign clk_pt_mode = ctl[CTL_CLK_PT];
    assign clr_pt_mode = ctl[CTL_CLR_PT];
    assign oe_sel      = ctl[CTL_OE_SEL];

    mc_cfg_loader #(
        .N_PT(N_PT), .LIT_W(LIT_W), .CFG_W(CFG_W), .ADDR_W(ADDR_W)
    ) u_cfg (
        .clk(gclk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rows(rows), .ctl(ctl), .live(live)
    );

    mc_and_array #(
        .N_IN(N_IN), .N_PT(N_PT), .LIT_W(LIT_W)
    ) u_and (
        .din(din), .rows(rows), .pt(pt_w)
    );

    mc_or_select #(
        .N_PT(N_PT)
    ) u_or (
        .pt(pt_w), .sel(sel_w), .sum(sum_w)
    );

    mc_storage u_ff (
        .gclk(gclk), .rst_n(rst_n), .gclr_n(gclr_n),
        .pt_clk(pt_w[CLK_TERM]), .pt_clr(pt_w[CLR_TERM]),
        .clk_pt_mode(clk_pt_mode), .clr_pt_mode(clr_pt_mode),
        .d(sum_w), .q(cell_q)
    );

    assign cell_res = bypass_en ? sum_w : cell_q;
    assign fb_out   = live & cell_res;
    assign pin_out  = live & cell_res;
    assign pin_oe   = live & (oe_sel ? oe_b : oe_a);
endmodule

// File: rtl/mc_checker.sv
module mc_checker #(
    parameter int N_PT   = 5,
    parameter int ADDR_W = 3
) (
    input logic              gclk,
    input logic              rst_n,
    input logic              gclr_n,
    input logic              oe_a,
    input logic              oe_b,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              fb_out,
    input logic              pin_oe,
    input logic              live,
    input logic              bypass_en,
    input logic              clk_pt_mode,
    input logic              clr_pt_mode,
    input logic [N_PT-1:0]   sel_w,
    input logic              sum_w
);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(N_PT);

    assert_mask_after_field_R9: assert property (@(posedge gclk) disable iff (!rst_n)
        (cfg_we && cfg_addr <= CTL_ADDR) |=> (fb_out == 1'b0 && pin_oe == 1'b0));

    assert_oe_source_R8: assert property (@(posedge gclk) disable iff (!rst_n)
        pin_oe |-> (oe_a || oe_b));

    assert_empty_sum_R3: assert property (@(posedge gclk) disable iff (!rst_n)
        (sel_w == '0) |-> (sum_w == 1'b0));

    assert_reg_capture_R4: assert property (@(posedge gclk) disable iff (!rst_n)
        (live && !bypass_en && !clk_pt_mode && !clr_pt_mode && gclr_n && !cfg_we)
        |=> (!gclr_n || fb_out == $past(sum_w)));

    assert_global_clear_R6: assert property (@(posedge gclk) disable iff (!rst_n)
        (live && !bypass_en && !clr_pt_mode && !gclr_n) |-> (fb_out == 1'b0));
endmodule

bind macrocell_pterm mc_checker #(.N_PT(N_PT), .ADDR_W(ADDR_W)) u_chk (
    .gclk(gclk), .rst_n(rst_n), .gclr_n(gclr_n), .oe_a(oe_a), .oe_b(oe_b),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .fb_out(fb_out), .pin_oe(pin_oe),
    .live(live), .bypass_en(bypass_en), .clk_pt_mode(clk_pt_mode),
    .clr_pt_mode(clr_pt_mode), .sel_w(sel_w), .sum_w(sum_w)
);

// File: tb/sim_macrocell_pterm.sv
module sim_macrocell_pterm;
    localparam int N_IN = 8;
    localparam int N_PT = 5;
    localparam int LIT_W = 16;
    localparam int CFG_W = 16;
    localparam int ADDR_W = 3;

    logic gclk = 1'b0;
    always #10 gclk = ~gclk;

    logic              rst_n = 1'b0;
    logic              gclr_n = 1'b1;
    logic              oe_a = 1'b1;
    logic              oe_b = 1'b0;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [CFG_W-1:0]  cfg_wdata = '0;
    logic [N_IN-1:0]   din = '0;
    logic              fb_out, pin_out, pin_oe;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [LIT_W-1:0] m_rows [N_PT];
    logic [N_PT-1:0]  m_sel;
    logic             m_oesel;

    macrocell_pterm #(.N_IN(N_IN), .N_PT(N_PT)) u0 (
        .gclk(gclk), .rst_n(rst_n), .gclr_n(gclr_n), .oe_a(oe_a), .oe_b(oe_b),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .din(din),
        .fb_out(fb_out), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic m_term(logic [LIT_W-1:0] r, logic [N_IN-1:0] d);
        if (r == '0) return 1'b0;
        for (int k = 0; k < N_IN; k++) begin
            if (r[2*k] && !d[k]) return 1'b0;
            if (r[2*k+1] && d[k]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic m_sum(logic [N_IN-1:0] d);
        logic s = 1'b0;
        for (int i = 0; i < N_PT; i++) s |= m_sel[i] & m_term(m_rows[i], d);
        return s;
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: got %b expected %b", req, $time, act, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [CFG_W-1:0] d);
        @(negedge gclk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge gclk);
        cfg_we = 1'b0;
        #2;
    endtask

    task automatic load_row(int i, logic [LIT_W-1:0] r);
        m_rows[i] = r;
        wr(ADDR_W'(i), r);
    endtask

    task automatic load_ctl(logic [N_PT-1:0] sel, bit byp, bit ckpt, bit crpt, bit oes);
        m_sel = sel; m_oesel = oes;
        wr(ADDR_W'(N_PT), CFG_W'({oes, crpt, ckpt, byp, 3'b000, sel}));
    endtask

    task automatic commit();
        wr(ADDR_W'(N_PT + 1), '0);
    endtask

    function automatic logic [LIT_W-1:0] rand_row();
        logic [LIT_W-1:0] r = '0;
        int c;
        if ($urandom % 8 == 0) return '0;
        for (int k = 0; k < N_IN; k++) begin
            c = $urandom % 8;
            if (c == 0) r[2*k] = 1'b1;
            else if (c == 1) r[2*k+1] = 1'b1;
        end
        return r;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired: got hang expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_0c11));
        for (int i = 0; i < N_PT; i++) m_rows[i] = '0;
        repeat (3) @(negedge gclk);
        rst_n = 1'b1;
        #2;
        check("R9 reset fb_out", fb_out, 1'b0);
        check("R9 reset pin_oe", pin_oe, 1'b0);

        // two-term example: A=din0 B=din1 C=din2 D=din3
        load_row(0, 16'h0091);
        load_row(1, 16'h0094);
        load_row(2, 16'h0000);
        load_row(3, 16'h0000);
        load_row(4, 16'h0000);
        load_ctl(5'b00011, 1, 0, 0, 0);
        din = 8'b0000_0101;
        #2;
        check("R9 masked before commit fb_out", fb_out, 1'b0);
        check("R9 masked before commit pin_oe", pin_oe, 1'b0);
        commit();
        for (int v = 0; v < 16; v++) begin
            din = 8'(v);
            #2;
            check("R3 example f", fb_out, (din[0] | din[1]) & din[2] & ~din[3]);
            check("R7 pin_out", pin_out, fb_out);
        end

        // empty selection and empty selected row
        load_ctl(5'b00000, 1, 0, 0, 0);
        commit();
        din = 8'b0000_0101; #2;
        check("R3 no term selected", fb_out, 1'b0);
        load_ctl(5'b00100, 1, 0, 0, 0);
        commit();
        for (int v = 0; v < 4; v++) begin
            din = 8'($urandom); #2;
            check("R2 empty row", fb_out, 1'b0);
        end

        // reconfiguration masking and ignored address
        load_ctl(5'b00011, 1, 0, 0, 0);
        commit();
        din = 8'b0000_0101; oe_a = 1'b1; #2;
        check("R3 live again", fb_out, 1'b1);
        wr(ADDR_W'(N_PT + 2), 16'hFFFF);
        check("R10 ignored write fb_out", fb_out, 1'b1);
        check("R10 ignored write pin_oe", pin_oe, 1'b1);
        load_row(2, 16'h0000);
        check("R9 field write masks fb_out", fb_out, 1'b0);
        check("R9 field write masks pin_oe", pin_oe, 1'b0);
        commit();
        check("R9 commit restores", fb_out, 1'b1);

        // random combinational configurations
        for (int t = 0; t < 150; t++) begin
            for (int i = 0; i < N_PT; i++) load_row(i, rand_row());
            load_ctl(5'($urandom), 1, 0, 0, 1'($urandom));
            commit();
            for (int v = 0; v < 6; v++) begin
                @(negedge gclk);
                din = 8'($urandom); oe_a = 1'($urandom); oe_b = 1'($urandom);
                #2;
                check("R1 R2 R3 random sum", fb_out, m_sum(din));
                check("R8 oe select", pin_oe, m_oesel ? oe_b : oe_a);
            end
        end
        oe_a = 1'b1;

        // registered on global clock
        load_row(0, 16'h0091); load_row(1, 16'h0094);
        load_row(2, 16'h0000); load_row(3, 16'h0000); load_row(4, 16'h0000);
        load_ctl(5'b00011, 0, 0, 0, 0);
        commit();
        for (int v = 0; v < 10; v++) begin
            logic old_q, new_d;
            @(negedge gclk);
            old_q = fb_out;
            din = 8'($urandom % 16);
            new_d = m_sum(din);
            #2;
            check("R4 holds before edge", fb_out, old_q);
            @(posedge gclk); #2;
            check("R4 loads on edge", fb_out, new_d);
        end

        // global clear
        din = 8'b0000_0101;
        @(posedge gclk); #2;
        check("R4 set before clear", fb_out, 1'b1);
        @(negedge gclk); gclr_n = 1'b0; #2;
        check("R6 global clear async", fb_out, 1'b0);
        @(posedge gclk); #2;
        check("R6 clear beats edge", fb_out, 1'b0);
        @(negedge gclk); gclr_n = 1'b1;
        @(posedge gclk); #2;
        check("R6 release then load", fb_out, 1'b1);

        // product-term clock: term4 = din7, sum = term0 = din0
        load_row(0, 16'h0001); load_row(1, 16'h0000);
        load_row(2, 16'h0000); load_row(3, 16'h1000); load_row(4, 16'h4000);
        load_ctl(5'b00001, 0, 1, 0, 0);
        commit();
        @(negedge gclk); din = 8'h00; gclr_n = 1'b0;
        @(negedge gclk); gclr_n = 1'b1;
        din = 8'h01;
        repeat (2) @(posedge gclk);
        #2;
        check("R5 gclk ignored", fb_out, 1'b0);
        @(negedge gclk); din = 8'h81; #2;
        check("R5 term clock rise", fb_out, 1'b1);
        @(negedge gclk); din = 8'h80;
        repeat (2) @(posedge gclk);
        #2;
        check("R5 holds without term edge", fb_out, 1'b1);
        @(negedge gclk); din = 8'h00; #2;
        check("R5 falling term no load", fb_out, 1'b1);
        @(negedge gclk); din = 8'h80; #2;
        check("R5 term clock loads 0", fb_out, 1'b0);

        // product-term clear: term3 = din6
        load_ctl(5'b00001, 0, 0, 1, 0);
        commit();
        @(negedge gclk); din = 8'h01;
        @(posedge gclk); #2;
        check("R6 load before term clear", fb_out, 1'b1);
        @(negedge gclk); gclr_n = 1'b0;
        @(posedge gclk); #2;
        check("R6 gclr_n ignored", fb_out, 1'b1);
        @(negedge gclk); gclr_n = 1'b1; din = 8'h41; #2;
        check("R6 term clear async", fb_out, 1'b0);
        @(posedge gclk); #2;
        check("R6 term clear beats edge", fb_out, 1'b0);
        @(negedge gclk); din = 8'h01; #2;
        check("R6 stays 0 until edge", fb_out, 1'b0);
        @(posedge gclk); #2;
        check("R6 load after release", fb_out, 1'b1);

        finish_run();
    end
endmodule